// File: doc/BRIEF.md
# Two-Level Threshold Network Word Adder

This block adds NW unsigned words in one combinational pass. Each word is log2(NW) bits wide. The result is the full 2·log2(NW)-bit total. Internally, every result bit is produced by a network two gates deep. Each gate is a modelled linear threshold element: it forms a signed integer sum of weighted inputs plus a constant, and outputs 1 when that value is zero or more. A word bit in column j always enters a gate with weight 2^j.

In the first level, the gates for result bit i detect how many multiples of 2^(i+1) the partial total of columns 0..i has reached. The second-level gate for bit i subtracts those counts from the partial total as a telescopic sum and tests the remainder against 2^i. The low bits, up to log2(NW)−2, each own their first-level gates. The gate set that serves bit log2(NW)−1 is built once over the full total. All higher result bits reuse a subset of it, so they need only their own second-level gate.

An optional output register, on by default, holds the result for one clock so the block can be driven in a clocked harness. The default configuration adds 8 words of 3 bits into a 6-bit sum.

Top module: `tsum_block_adder`

## Requirements
- R1: With the output register enabled, `sum` equals the unsigned integer total of all NW input words one clock after they are presented.
- R2: While `rst_n` is low, the registered `sum` is cleared to 0 at each rising clock edge.
- R3: Word w occupies `din[w*LW +: LW]` with LW = log2(NW), and its bit j counts as 2^j. Every word position carries the same weight.
- R4: When all input bits are 1, `sum` equals NW·(NW−1), which is 56 for the default, and its most significant bit is set.
- R5: When all input bits are 0, `sum` is 0.
- R6: `sum` never exceeds NW·(NW−1).
- R7: If `din` is held steady across consecutive edges after reset, `sum` does not change.
- R8: Totals that fall exactly on, or one below, a multiple of 2^LW or a power of two give the correct sum. These are the limits of the shared first-level gates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| din | input | NW*log2(NW) | Flat bus of NW words, with word 0 in the lowest bits |
| sum | output | 2*log2(NW) | Total of the input words |

## Verification
The bench aims at the interval boundaries where telescopic terms switch. It uses totals such as 7, 8, 15, 16, 31, 32 and 56. A first-level gate whose limit is off by one would flip a single result bit exactly at one of those totals. If the shared gates were wired to the wrong upper bits, the error would show only at totals of 16 and above, such as 24, 32 or 48. Each word position is driven alone with its maximum value, so a misplaced slice or a wrong column weight gives a wrong total. A long pseudo-random run compares every result with plain integer addition.

// File: rtl/tsum_block_adder.sv
module tsum_block_adder #(
  parameter int NW      = 8,
  parameter bit REG_OUT = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NW*$clog2(NW)-1:0]    din,
  output logic [2*$clog2(NW)-1:0]     sum
);
  localparam int LW = $clog2(NW);
  localparam int OW = 2 * LW;
  localparam int AW = OW + 2;
  localparam int KT = (NW * ((1 << LW) - 1)) >> LW;

  logic signed [AW-1:0] part [LW];
  logic [KT-1:0]        shg;
  logic [OW-1:0]        s_c;

  always_comb begin
    for (int i = 0; i < LW; i++) begin
      part[i] = '0;
      for (int w = 0; w < NW; w++)
        for (int j = 0; j <= i; j++)
          if (din[w*LW+j]) part[i] = part[i] + AW'(1 << j);
    end
  end

  generate
    for (genvar k = 0; k < KT; k++) begin : g_shared
      assign shg[k] = (part[LW-1] - AW'((k + 1) << LW)) >= 0;
    end

    for (genvar i = 0; i < LW - 1; i++) begin : g_low
      localparam int K = (NW * ((1 << (i + 1)) - 1)) >> (i + 1);
      logic [K-1:0]         g;
      logic signed [AW-1:0] acc;
      for (genvar k = 0; k < K; k++) begin : g_l1
        assign g[k] = (part[i] - AW'((k + 1) << (i + 1))) >= 0;
      end
      always_comb begin
        acc = part[i] - AW'(1 << i);
        for (int k = 0; k < K; k++)
          if (g[k]) acc = acc - AW'(1 << (i + 1));
      end
      assign s_c[i] = acc >= 0;
    end

    for (genvar i = LW - 1; i < OW; i++) begin : g_high
      localparam int STEP = 1 << (i + 1 - LW);
      logic signed [AW-1:0] acc;
      always_comb begin
        acc = part[LW-1] - AW'(1 << i);
        for (int k = 0; k < KT; k++)
          if (((k + 1) % STEP) == 0 && shg[k]) acc = acc - AW'(1 << (i + 1));
      end
      assign s_c[i] = acc >= 0;
    end

    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk)
        if (!rst_n) sum <= '0;
        else        sum <= s_c;
    end else begin : g_comb
      assign sum = s_c;
    end
  endgenerate
endmodule

// File: rtl/tsum_block_adder_chk.sv
module tsum_block_adder_chk #(
  parameter int NW = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NW*$clog2(NW)-1:0] din,
  input logic [2*$clog2(NW)-1:0]  sum
);
  localparam int LW = $clog2(NW);
  localparam int OW = 2 * LW;

  function automatic logic [OW-1:0] plain_total(input logic [NW*LW-1:0] v);
    logic [OW-1:0] t;
    t = '0;
    for (int w = 0; w < NW; w++) t = t + OW'(v[w*LW +: LW]);
    return t;
  endfunction

  // R1
  total_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sum == plain_total($past(din)));

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> sum == '0);

  // R6
  range_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sum <= OW'(NW * (NW - 1)));

  // R7
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(din)) |=> $stable(sum));
endmodule

bind tsum_block_adder tsum_block_adder_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .sum(sum));

// File: tb/tsum_block_adder_bench.sv
`timescale 1ns/1ps
module tsum_block_adder_bench;
  localparam int NW = 8;
  localparam int LW = 3;
  localparam int OW = 6;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [NW*LW-1:0]  din = '0;
  logic [OW-1:0]     sum;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tsum_block_adder #(.NW(NW), .REG_OUT(1)) u_tsum_block_adder (
    .clk(clk), .rst_n(rst_n), .din(din), .sum(sum));

  function automatic int ref_total(input logic [NW*LW-1:0] v);
    int t = 0;
    for (int w = 0; w < NW; w++) t += int'(v[w*LW +: LW]);
    return t;
  endfunction

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(sum) != exp) begin
      errors++;
      $display("FAIL %s: sum=%0d expected=%0d din=%h", req, sum, exp, din);
    end
  endtask

  task automatic apply(input logic [NW*LW-1:0] v, input string req);
    @(negedge clk);
    din = v;
    @(negedge clk);
    check(req, ref_total(v));
  endtask

  function automatic logic [NW*LW-1:0] make_total(input int t);
    logic [NW*LW-1:0] v = '0;
    int rem = t;
    for (int w = 0; w < NW; w++) begin
      int x = (rem > 7) ? 7 : rem;
      v[w*LW +: LW] = LW'(x);
      rem -= x;
    end
    return v;
  endfunction

  task automatic t_reset;
    rst_n = 0;
    din = '1;
    repeat (3) @(negedge clk);
    check("R2 reset", 0);
    rst_n = 1;
  endtask

  task automatic t_zero;
    apply('0, "R5 all zero");
  endtask

  task automatic t_full;
    apply('1, "R4 all ones");
    checks++;
    if (sum[OW-1] !== 1'b1) begin
      errors++;
      $display("FAIL R4 msb: sum=%0d expected msb set", sum);
    end
  endtask

  task automatic t_positions;
    for (int w = 0; w < NW; w++) begin
      logic [NW*LW-1:0] v = '0;
      v[w*LW +: LW] = '1;
      apply(v, "R3 word position max");
      v = '0;
      v[w*LW + 2] = 1'b1;
      apply(v, "R3 column weight");
    end
  endtask

  task automatic t_limits;
    int lims[14] = '{1, 2, 3, 4, 7, 8, 15, 16, 23, 24, 31, 32, 48, 55};
    foreach (lims[n]) begin
      apply(make_total(lims[n]), "R8 interval limit");
      checks++;
      if (int'(sum) != lims[n]) begin
        errors++;
        $display("FAIL R8 limit: sum=%0d expected=%0d", sum, lims[n]);
      end
    end
  endtask

  task automatic t_hold;
    logic [OW-1:0] first;
    apply(make_total(37), "R7 hold start");
    first = sum;
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (sum !== first) begin
        errors++;
        $display("FAIL R7 hold: sum=%0d expected=%0d", sum, first);
      end
    end
  endtask

  task automatic t_random;
    logic [31:0] lf = 32'hACE1_2345;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      apply(lf[NW*LW-1:0], "R1 random total");
      if (int'(sum) > NW * (NW - 1)) begin
        errors++;
        $display("FAIL R6 bound: sum=%0d expected<=%0d", sum, NW * (NW - 1));
      end
      checks++;
    end
  endtask

  initial begin
    t_reset();
    t_zero();
    t_full();
    t_positions();
    t_limits();
    t_hold();
    t_random();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule